// File: doc/BRIEF.md
# Flash Page Remapping Write Controller

This block maps logical pages onto a modelled flash array made of erase blocks. Each erase block holds a fixed number of pages. A client issues one whole-page read or one whole-page write at a time through a simple request port. The block reports through `busy` and a one-cycle `done` pulse. A physical page can be programmed only once between erases. A write to a page that has not been programmed since its block was last erased is done in place. A write to a page that already holds data starts a relocation instead:

- pick the lowest-numbered unmapped physical block;
- erase it;
- program the new data into it;
- sweep the old block and copy every other page that holds data;
- point the logical block at the new physical block;
- release and erase the old block.

Every block has its own erase counter. A block whose count reaches a parameterised limit raises its bit in a wear vector. The state machine has nine states:

- IDLE: wait for a request.
- READ: fetch one page.
- PROG: program in place.
- ERASE_NEW: a timed erase of the fresh block.
- WRITE_NEW: program the fresh page.
- COPY: one page per cycle.
- REMAP: switch the map entry and swap the free flags.
- ERASE_OLD: a timed erase of the released block.
- FINISH: pulse `done`.

The transitions are:

- IDLE to READ on a read.
- IDLE to PROG on a write to an unprogrammed page.
- IDLE to ERASE_NEW on a write to a programmed page.
- READ to FINISH, and PROG to FINISH.
- ERASE_NEW to WRITE_NEW when its erase timer expires.
- WRITE_NEW to COPY.
- COPY to REMAP after the last page index.
- REMAP to ERASE_OLD.
- ERASE_OLD to FINISH when its timer expires.
- FINISH to IDLE.

Top module: `ftl_remap_ctrl`

## Requirements
- R1: A read returns the whole page last written to that logical address. A read of a page never written since its block was erased returns all ones.
- R2: A write to a logical page not yet programmed in its current physical block is programmed in place, and its effect is visible to the next read.
- R3: No physical page is programmed while it still holds data from before its block's last erase.
- R4: A write to an already programmed page moves the logical block to the lowest-numbered unmapped physical block. Afterwards the new data reads back, the other programmed pages of that logical block keep their data, and other logical blocks are not disturbed.
- R5: The relocation copies only pages that hold data and does not copy the page being replaced. Pages never written still read as all ones after the move.
- R6: `busy` rises on the edge that accepts a request. It stays high 2 cycles for a read or an in-place write. It stays high 2*ERASE_CYC+PAGES+3 cycles for a relocation.
- R7: `done` is high for exactly one cycle per request, and that cycle is the last cycle in which `busy` is high.
- R8: `req_valid` is ignored whenever `busy` is high, including the cycle in which `done` is high. Such a request changes no page.
- R9: Each physical block counts its erases. Its `worn` bit goes high when the count reaches WEAR_LIMIT and then stays high.
- R10: After reset, `busy`, `done` and `worn` are zero. Logical block i maps to physical block i, and every page reads as all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken only while not busy |
| req_write | input | 1 | 1 = page write, 0 = page read |
| req_addr | input | clog2(LBLK)+clog2(PAGES) | Logical page: upper bits logical block, lower bits page index |
| req_wdata | input | DW | Page data for a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Data of the most recent read, held until the next read |
| worn | output | PBLK | Per physical block: erase count reached WEAR_LIMIT |

## Verification
Two events can fall into the same cycle: completion of a relocation and arrival of a new request. The FINISH cycle is the one where `done` is high while `busy` is still asserted. The bench presents a write to a fresh page in exactly that cycle, and presents another write in the middle of the copy sweep. It then checks that `busy` drops on the next cycle and does not rise again. It also checks that the relocation took its full cycle count and that both targeted pages still read as all ones.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_READ,
        ST_PROG,
        ST_ERASE_NEW,
        ST_WRITE_NEW,
        ST_COPY,
        ST_REMAP,
        ST_ERASE_OLD,
        ST_FINISH
    } ftl_state_e;

endpackage

// File: rtl/ftl_page_store.sv
module ftl_page_store #(
    parameter int PBLK  = 6,
    parameter int PAGES = 32,
    parameter int DW    = 16,
    localparam int BW   = $clog2(PBLK),
    localparam int PW   = $clog2(PAGES),
    localparam int AW   = $clog2(PBLK * PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_blk,
    input  logic [PW-1:0] wr_pg,
    input  logic [DW-1:0] wr_data,
    input  logic          ers_en,
    input  logic [BW-1:0] ers_blk,
    input  logic [BW-1:0] rd_blk,
    input  logic [PW-1:0] rd_pg,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    logic [DW-1:0]    mem [PBLK*PAGES];
    logic [PAGES-1:0] vld [PBLK];

    function automatic logic [AW-1:0] flat(input logic [BW-1:0] b, input logic [PW-1:0] p);
        return AW'(int'(b) * PAGES + int'(p));
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[flat(wr_blk, wr_pg)] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < PBLK; b++) vld[b] <= '0;
        end else begin
            for (int b = 0; b < PBLK; b++) begin
                if (ers_en && ers_blk == BW'(b))
                    vld[b] <= '0;
                else if (wr_en && wr_blk == BW'(b))
                    vld[b][wr_pg] <= 1'b1;
            end
        end
    end

    assign rd_valid = vld[rd_blk][rd_pg];
    assign rd_data  = rd_valid ? mem[flat(rd_blk, rd_pg)] : '1;

    // R3
    prog_erased_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !vld[wr_blk][wr_pg]);

    // R3
    no_prog_on_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ers_en) |-> (wr_blk != ers_blk));

endmodule

// File: rtl/ftl_wear_track.sv
module ftl_wear_track #(
    parameter int PBLK       = 6,
    parameter int WEAR_LIMIT = 100000,
    localparam int BW        = $clog2(PBLK),
    localparam int CW        = $clog2(WEAR_LIMIT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc_en,
    input  logic [BW-1:0]   inc_blk,
    output logic [PBLK-1:0] worn
);

    for (genvar b = 0; b < PBLK; b++) begin : g_cnt
        logic [CW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt <= '0;
            else if (inc_en && inc_blk == BW'(b) && cnt != CW'(WEAR_LIMIT))
                cnt <= cnt + 1'b1;
        end

        assign worn[b] = (cnt == CW'(WEAR_LIMIT));

        // R9
        worn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            worn[b] |=> worn[b]);
    end

endmodule

// File: rtl/ftl_blk_alloc.sv
module ftl_blk_alloc #(
    parameter int PBLK = 6,
    localparam int BW  = $clog2(PBLK)
) (
    input  logic [PBLK-1:0] free_vec,
    output logic [BW-1:0]   pick,
    output logic            found
);

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = PBLK - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                pick  = BW'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ftl_remap_ctrl.sv
module ftl_remap_ctrl
    import ftl_pkg::*;
#(
    parameter int LBLK       = 4,
    parameter int PBLK       = 6,
    parameter int PAGES      = 32,
    parameter int DW         = 16,
    parameter int ERASE_CYC  = 16,
    parameter int WEAR_LIMIT = 100000,
    localparam int LW        = $clog2(LBLK),
    localparam int PW        = $clog2(PAGES),
    localparam int BW        = $clog2(PBLK),
    localparam int AW        = LW + PW,
    localparam int EW        = $clog2(ERASE_CYC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   rd_data,
    output logic [PBLK-1:0] worn
);

    ftl_state_e state, state_nx;

    logic          op_wr;
    logic [LW-1:0] lblk_q;
    logic [PW-1:0] pg_q;
    logic [DW-1:0] wdat_q;
    logic [BW-1:0] old_q, new_q;
    logic [PW-1:0] idx;
    logic [EW-1:0] ecnt;
    logic [BW-1:0] l2p [LBLK];
    logic [PBLK-1:0] free_r;
    logic [DW-1:0] rd_q;

    logic          accept;
    logic [LW-1:0] req_lblk;
    logic [PW-1:0] req_pg;
    logic          erase_last;

    logic          st_wr_en, st_ers_en, st_rd_valid;
    logic [BW-1:0] st_wr_blk, st_ers_blk, st_rd_blk;
    logic [PW-1:0] st_wr_pg, st_rd_pg;
    logic [DW-1:0] st_wr_data, st_rd_data;
    logic [BW-1:0] alloc_pick;
    logic          alloc_found;

    assign req_lblk   = req_addr[AW-1:PW];
    assign req_pg     = req_addr[PW-1:0];
    assign accept     = req_valid && (state == ST_IDLE);
    assign erase_last = (ecnt == EW'(ERASE_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) begin
                if (!req_write)       state_nx = ST_READ;
                else if (st_rd_valid) state_nx = ST_ERASE_NEW;
                else                  state_nx = ST_PROG;
            end
            ST_READ:      state_nx = ST_FINISH;
            ST_PROG:      state_nx = ST_FINISH;
            ST_ERASE_NEW: if (erase_last) state_nx = ST_WRITE_NEW;
            ST_WRITE_NEW: state_nx = ST_COPY;
            ST_COPY:      if (idx == PW'(PAGES - 1)) state_nx = ST_REMAP;
            ST_REMAP:     state_nx = ST_ERASE_OLD;
            ST_ERASE_OLD: if (erase_last) state_nx = ST_FINISH;
            ST_FINISH:    state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // outputs and store controls
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_FINISH);
        st_wr_en   = 1'b0;
        st_wr_blk  = old_q;
        st_wr_pg   = pg_q;
        st_wr_data = wdat_q;
        st_ers_en  = 1'b0;
        st_ers_blk = new_q;
        st_rd_blk  = old_q;
        st_rd_pg   = pg_q;
        unique case (state)
            ST_IDLE: begin
                st_rd_blk = l2p[req_lblk];
                st_rd_pg  = req_pg;
            end
            ST_PROG: st_wr_en = 1'b1;
            ST_ERASE_NEW: st_ers_en = erase_last;
            ST_WRITE_NEW: begin
                st_wr_en  = 1'b1;
                st_wr_blk = new_q;
            end
            ST_COPY: begin
                st_rd_pg   = idx;
                st_wr_en   = (idx != pg_q) && st_rd_valid;
                st_wr_blk  = new_q;
                st_wr_pg   = idx;
                st_wr_data = st_rd_data;
            end
            ST_ERASE_OLD: begin
                st_ers_en  = erase_last;
                st_ers_blk = old_q;
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_wr  <= 1'b0;
            lblk_q <= '0;
            pg_q   <= '0;
            wdat_q <= '0;
            old_q  <= '0;
            new_q  <= '0;
            idx    <= '0;
            ecnt   <= '0;
            rd_q   <= '1;
            for (int i = 0; i < LBLK; i++) l2p[i] <= BW'(i);
            for (int i = 0; i < PBLK; i++) free_r[i] <= (i >= LBLK);
        end else begin
            if (accept) begin
                op_wr  <= req_write;
                lblk_q <= req_lblk;
                pg_q   <= req_pg;
                wdat_q <= req_wdata;
                old_q  <= l2p[req_lblk];
                new_q  <= alloc_pick;
            end
            if ((state == ST_ERASE_NEW || state == ST_ERASE_OLD) && !erase_last)
                ecnt <= ecnt + 1'b1;
            else
                ecnt <= '0;
            idx <= (state == ST_COPY) ? idx + 1'b1 : '0;
            if (state == ST_READ) rd_q <= st_rd_data;
            if (state == ST_REMAP) begin
                l2p[lblk_q]   <= new_q;
                free_r[new_q] <= 1'b0;
                free_r[old_q] <= 1'b1;
            end
        end
    end

    assign rd_data = rd_q;

    ftl_page_store #(.PBLK(PBLK), .PAGES(PAGES), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st_wr_en),
        .wr_blk   (st_wr_blk),
        .wr_pg    (st_wr_pg),
        .wr_data  (st_wr_data),
        .ers_en   (st_ers_en),
        .ers_blk  (st_ers_blk),
        .rd_blk   (st_rd_blk),
        .rd_pg    (st_rd_pg),
        .rd_data  (st_rd_data),
        .rd_valid (st_rd_valid)
    );

    ftl_wear_track #(.PBLK(PBLK), .WEAR_LIMIT(WEAR_LIMIT)) u_wear (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (st_ers_en),
        .inc_blk (st_ers_blk),
        .worn    (worn)
    );

    ftl_blk_alloc #(.PBLK(PBLK)) u_alloc (
        .free_vec (free_r),
        .pick     (alloc_pick),
        .found    (alloc_found)
    );

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R4
    fresh_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE_NEW) |-> (new_q != old_q && free_r[new_q] && alloc_found));

    // R6
    write_only_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG || state == ST_ERASE_NEW) |-> op_wr);

endmodule

// File: tb/tb_ftl_remap_ctrl.sv
module tb_ftl_remap_ctrl;

    localparam int LBLK = 2, PBLK = 3, PAGES = 32, DW = 16;
    localparam int ERASE_CYC = 4, WEAR_LIMIT = 3;
    localparam int AW = 6;
    localparam int RELOC_CYC = 2 * ERASE_CYC + PAGES + 3;
    localparam logic [DW-1:0] ONES = '1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            busy, done;
    logic [DW-1:0]   rd_data;
    logic [PBLK-1:0] worn;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ftl_remap_ctrl #(
        .LBLK(LBLK), .PBLK(PBLK), .PAGES(PAGES), .DW(DW),
        .ERASE_CYC(ERASE_CYC), .WEAR_LIMIT(WEAR_LIMIT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .worn(worn)
    );

    function automatic logic [AW-1:0] la(input int lb, input int pg);
        return AW'(lb * PAGES + pg);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // issue one request; returns busy cycle count, done pulses, done in last busy cycle
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int cyc, output int dones, output bit last_done);
        cyc = 0; dones = 0; last_done = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy && cyc < 1000) begin
            cyc++;
            if (done) dones++;
            last_done = done;
            @(negedge clk);
        end
    endtask

    task automatic rd_page(input logic [AW-1:0] a, output logic [DW-1:0] d);
        int c, n; bit l;
        issue(1'b0, a, '0, c, n, l);
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        chk(busy == 1'b0, "R10 busy", busy, 0);
        chk(done == 1'b0, "R10 done", done, 0);
        chk(worn == '0, "R10 worn", worn, 0);
        rd_page(la(1, 5), d);
        chk(d == ONES, "R10 R1 unwritten read", d, ONES);
    endtask

    task automatic t_inplace();
        int c, n; bit l; logic [DW-1:0] d;
        issue(1'b1, la(0, 3), 16'h1234, c, n, l);
        chk(c == 2, "R2 R6 in-place busy cycles", c, 2);
        chk(n == 1 && l, "R7 single done at end", n, 1);
        issue(1'b1, la(0, 7), 16'hBEEF, c, n, l);
        issue(1'b1, la(1, 0), 16'h5555, c, n, l);
        issue(1'b0, la(0, 3), '0, c, n, l);
        chk(c == 2, "R6 read busy cycles", c, 2);
        chk(n == 1 && l, "R7 read done", n, 1);
        chk(rd_data == 16'h1234, "R1 R2 readback", rd_data, 16'h1234);
    endtask

    task automatic t_overwrite();
        int c, n; bit l; logic [DW-1:0] d;
        issue(1'b1, la(0, 3), 16'hA5A5, c, n, l);
        chk(c == RELOC_CYC, "R6 R4 relocation busy cycles", c, RELOC_CYC);
        chk(n == 1 && l, "R7 relocation done", n, 1);
        rd_page(la(0, 3), d);
        chk(d == 16'hA5A5, "R4 new data", d, 16'hA5A5);
        rd_page(la(0, 7), d);
        chk(d == 16'hBEEF, "R4 copied page", d, 16'hBEEF);
        rd_page(la(0, 4), d);
        chk(d == ONES, "R5 unwritten page stays erased", d, ONES);
        rd_page(la(1, 0), d);
        chk(d == 16'h5555, "R4 other logical block", d, 16'h5555);
        issue(1'b1, la(0, 20), 16'h2020, c, n, l);
        chk(c == 2, "R2 in-place in relocated block", c, 2);
        rd_page(la(0, 20), d);
        chk(d == 16'h2020, "R2 readback relocated block", d, 16'h2020);
        chk(worn == '0, "R9 no wear after one move", worn, 0);
    endtask

    // requests during busy, including the done cycle (R8)
    task automatic t_busy_ignore();
        int c; logic [DW-1:0] d;
        c = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = la(0, 7); req_wdata = 16'h7777;
        @(negedge clk);
        while (busy && c < 1000) begin
            c++;
            req_valid = 1'b0;
            if (c == 10) begin
                req_valid = 1'b1; req_addr = la(1, 9); req_wdata = 16'h9999;
            end
            if (done) begin
                req_valid = 1'b1; req_addr = la(1, 10); req_wdata = 16'hAAAA;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(c == RELOC_CYC, "R8 relocation length unchanged", c, RELOC_CYC);
        chk(busy == 1'b0, "R8 done-cycle request ignored", busy, 0);
        @(negedge clk);
        chk(busy == 1'b0, "R8 still idle", busy, 0);
        rd_page(la(1, 9), d);
        chk(d == ONES, "R8 mid-busy write dropped", d, ONES);
        rd_page(la(1, 10), d);
        chk(d == ONES, "R8 done-cycle write dropped", d, ONES);
        rd_page(la(0, 7), d);
        chk(d == 16'h7777, "R4 second move data", d, 16'h7777);
        rd_page(la(0, 3), d);
        chk(d == 16'hA5A5, "R5 target-excluded copy kept others", d, 16'hA5A5);
        chk(worn == '0, "R9 no wear after two moves", worn, 0);
    endtask

    // blocks 0 and 2 alternate as new/old; third move brings both to 3 erases
    task automatic t_wear();
        int c, n; bit l; logic [DW-1:0] d;
        issue(1'b1, la(0, 3), 16'h3C3C, c, n, l);
        chk(worn == 3'b101, "R9 worn flags", worn, 3'b101);
        rd_page(la(0, 3), d);
        chk(d == 16'h3C3C, "R4 third move data", d, 16'h3C3C);
        rd_page(la(0, 20), d);
        chk(d == 16'h2020, "R4 third move copy", d, 16'h2020);
        chk(worn == 3'b101, "R9 worn sticky", worn, 3'b101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inplace();
        t_overwrite();
        t_busy_ignore();
        t_wear();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule